// File: doc/BRIEF.md
# Pixel Gain/Offset Input Demultiplexer

This block takes the per-pixel correction codes that arrive on one narrow, time-multiplexed 10-bit bus and sorts them into three colour channels. Every pixel slot carries six words. For each colour the offset code comes first and the gain code follows, and the colours arrive as red, then green, then blue. A pixel-start strobe marks the first word of a pixel. The block places each word in its own capture register. When the last word (blue gain) arrives, all six codes move together into output holding registers, so the analog stages downstream see one coherent set per pixel.

A mode input selects between these captured dynamic codes and fixed codes supplied from configuration registers. In fixed mode an alternate-pixel option applies a separate set of offset codes to even pixels. This cancels a systematic offset between neighbouring pixels that come from two different sensor rows. An even/odd pixel toggle supports this option. It restarts at each line start and flips on each pixel start.

Top module: `pix_code_demux`

## Requirements
- R1: After reset every code output is 0, `codeValid` is 0 and `codeOdd` is 0. Bus words that arrive before the first `pixStart` are ignored, so the outputs stay at 0 and no `codeValid` pulse occurs.
- R2: After `pixStart`, the words qualified by `wordValid` are taken in this slot order: red offset, red gain, green offset, green gain, blue offset, blue gain. A valid word in the same cycle as `pixStart` is the red offset. Cycles with `wordValid` low do not advance the slot. Channel index 0 is red, 1 is green and 2 is blue; channel c occupies bits [10c+9:10c] of `offCode` and `gainCode`.
- R3: All six codes update together at the clock edge that captures the blue gain word. `codeValid` is high in exactly the one cycle that follows that edge. At all other times the outputs hold their values.
- R4: Valid words that arrive after the blue gain word and before the next `pixStart` are ignored.
- R5: A `pixStart` in the middle of a pixel restarts capture at the red offset slot and discards the partial set. The outputs do not change until a later set completes.
- R6: When `modeDyn` is 0 at the transfer edge, `gainCode` takes `fixGain`. With `altEn` at 0, `offCode` takes `fixOffBase`. The values of the bus words have no effect.
- R7: When `modeDyn` is 0 and `altEn` is 1, even pixels take `fixOffEven` as their offset codes and odd pixels take `fixOffBase`. The gain codes still come from `fixGain`.
- R8: The pixel that starts together with `lineStart`, or the first pixel after a lone `lineStart`, is even. Each further `pixStart` toggles the parity. `codeOdd` reports the parity of the presented set (1 means odd).
- R9: When `modeDyn` is 1, the output codes are the captured bus words and `altEn` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Start of a scan line; restarts the even/odd parity |
| pixStart | input | 1 | First word of a pixel; restarts the slot counter |
| wordValid | input | 1 | Qualifies `wordIn` in this cycle |
| wordIn | input | 10 | Multiplexed offset/gain word |
| modeDyn | input | 1 | 1: captured per-pixel codes, 0: fixed codes |
| altEn | input | 1 | Alternate-pixel offset option in fixed mode |
| fixGain | input | 30 | Fixed gain codes, 10 bits per channel |
| fixOffBase | input | 30 | Fixed offset codes (odd pixels, or all pixels when the option is off) |
| fixOffEven | input | 30 | Fixed offset codes for even pixels when the option is on |
| offCode | output | 30 | Presented offset codes, 10 bits per channel |
| gainCode | output | 30 | Presented gain codes, 10 bits per channel |
| codeValid | output | 1 | One-cycle pulse when a new set is presented |
| codeOdd | output | 1 | Parity of the presented set |

## Verification
The assertions check the following on every cycle:
- the slot counter never leaves its range, and a restart always returns it to the red offset slot;
- `codeValid` is one cycle wide and follows each transfer;
- the outputs hold still between transfers;
- a dynamic transfer takes the blue gain from the bus word, and a fixed transfer takes the fixed gains;
- a line start forces the even parity.

Only the bench scenarios can show the full slot-to-channel mapping under gaps in `wordValid`. They also show that stray words and partial pixels are discarded, how the even/odd offset choice alternates across several pixels and lines, and that `altEn` has no effect in dynamic mode.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  // width of the slot index carried in the strobe struct (up to 7 channels)
  localparam int SLOT_W = 4;

  typedef struct packed {
    logic              capture; // a word is taken this cycle
    logic [SLOT_W-1:0] slot;    // slot the word belongs to
    logic              xfer;    // last slot taken: move set to outputs
    logic              setOdd;  // parity of the pixel being completed
  } pcdStrobe_t;
endpackage

// File: rtl/pcd_ctrl.sv
module pcd_ctrl
  import pcd_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineStart,
  input  logic       pixStart,
  input  logic       wordValid,
  output pcdStrobe_t strb
);
  localparam int NUM_SLOT = 2 * NUM_CH;
  localparam logic [SLOT_W-1:0] IDLE_SLOT = SLOT_W'(NUM_SLOT);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOT - 1);

  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] curSlot;
  logic              wordTake;
  logic              curOdd;
  logic              nextOdd;

  // pixStart forces the current word into the red offset slot
  always_comb begin
    curSlot  = pixStart ? '0 : slotCnt;
    wordTake = wordValid && (curSlot < IDLE_SLOT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= IDLE_SLOT;
    end else if (wordTake) begin
      slotCnt <= curSlot + SLOT_W'(1);
    end else if (pixStart) begin
      slotCnt <= '0;
    end
  end

  // even/odd pixel parity
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOdd  <= 1'b0;
      nextOdd <= 1'b0;
    end else if (pixStart) begin
      curOdd  <= lineStart ? 1'b0 : nextOdd;
      nextOdd <= lineStart ? 1'b1 : ~nextOdd;
    end else if (lineStart) begin
      nextOdd <= 1'b0;
    end
  end

  always_comb begin
    strb.capture = wordTake;
    strb.slot    = curSlot;
    strb.xfer    = wordTake && (curSlot == LAST_SLOT);
    strb.setOdd  = curOdd;
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt <= IDLE_SLOT); // R2

  AST_RESTART_RED: assert property (@(posedge clk) disable iff (!rstN)
    pixStart |=> (slotCnt <= SLOT_W'(1))); // R5

  AST_LINE_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (pixStart && lineStart) |=> !curOdd); // R8

  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (slotCnt == IDLE_SLOT && !pixStart) |-> !strb.capture); // R4
endmodule

// File: rtl/pcd_dpath.sv
module pcd_dpath
  import pcd_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pcdStrobe_t               strb,
  input  logic [CODE_W-1:0]        wordIn,
  input  logic                     modeDyn,
  input  logic                     altEn,
  input  logic [NUM_CH*CODE_W-1:0] fixGain,
  input  logic [NUM_CH*CODE_W-1:0] fixOffBase,
  input  logic [NUM_CH*CODE_W-1:0] fixOffEven,
  output logic [NUM_CH*CODE_W-1:0] offCode,
  output logic [NUM_CH*CODE_W-1:0] gainCode,
  output logic                     codeValid,
  output logic                     codeOdd
);
  localparam int NUM_SLOT = 2 * NUM_CH;
  localparam int SET_W    = NUM_CH * CODE_W;

  // capture registers for every slot except the last one
  logic [CODE_W-1:0] capReg [NUM_SLOT-1];
  logic [CODE_W-1:0] dynSet [NUM_SLOT];
  logic [SET_W-1:0]  nextOff;
  logic [SET_W-1:0]  nextGain;

  genvar s;
  generate
    for (s = 0; s < NUM_SLOT - 1; s++) begin : g_cap
      always_ff @(posedge clk) begin
        if (!rstN) begin
          capReg[s] <= '0;
        end else if (strb.capture && strb.slot == SLOT_W'(s)) begin
          capReg[s] <= wordIn;
        end
      end
      assign dynSet[s] = capReg[s];
    end
  endgenerate
  // the last word goes straight into the output registers
  assign dynSet[NUM_SLOT-1] = wordIn;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic [CODE_W-1:0] fixOffSel;
      always_comb begin
        fixOffSel = (altEn && !strb.setOdd) ? fixOffEven[c*CODE_W +: CODE_W]
                                            : fixOffBase[c*CODE_W +: CODE_W];
        if (modeDyn) begin
          nextOff[c*CODE_W +: CODE_W]  = dynSet[2*c];
          nextGain[c*CODE_W +: CODE_W] = dynSet[2*c+1];
        end else begin
          nextOff[c*CODE_W +: CODE_W]  = fixOffSel;
          nextGain[c*CODE_W +: CODE_W] = fixGain[c*CODE_W +: CODE_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offCode   <= '0;
      gainCode  <= '0;
      codeOdd   <= 1'b0;
      codeValid <= 1'b0;
    end else begin
      codeValid <= strb.xfer;
      if (strb.xfer) begin
        offCode  <= nextOff;
        gainCode <= nextGain;
        codeOdd  <= strb.setOdd;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> codeValid); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !codeValid |-> ($stable(offCode) && $stable(gainCode))); // R3

  AST_DYN_LAST_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xfer && modeDyn) |=>
      (gainCode[SET_W-1 -: CODE_W] == $past(wordIn))); // R9

  AST_FIX_GAIN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xfer && !modeDyn) |=> (gainCode == $past(fixGain))); // R6
endmodule

// File: rtl/pix_code_demux.sv
module pix_code_demux
  import pcd_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lineStart,
  input  logic                     pixStart,
  input  logic                     wordValid,
  input  logic [CODE_W-1:0]        wordIn,
  input  logic                     modeDyn,
  input  logic                     altEn,
  input  logic [NUM_CH*CODE_W-1:0] fixGain,
  input  logic [NUM_CH*CODE_W-1:0] fixOffBase,
  input  logic [NUM_CH*CODE_W-1:0] fixOffEven,
  output logic [NUM_CH*CODE_W-1:0] offCode,
  output logic [NUM_CH*CODE_W-1:0] gainCode,
  output logic                     codeValid,
  output logic                     codeOdd
);
  pcdStrobe_t strb;

  pcd_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .pixStart  (pixStart),
    .wordValid (wordValid),
    .strb      (strb)
  );

  pcd_dpath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wordIn     (wordIn),
    .modeDyn    (modeDyn),
    .altEn      (altEn),
    .fixGain    (fixGain),
    .fixOffBase (fixOffBase),
    .fixOffEven (fixOffEven),
    .offCode    (offCode),
    .gainCode   (gainCode),
    .codeValid  (codeValid),
    .codeOdd    (codeOdd)
  );

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> !codeValid); // R3
endmodule

// File: tb/test_pix_code_demux.sv
`timescale 1ns/1ps
module test_pix_code_demux;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineStart = 1'b0, pixStart = 1'b0, wordValid = 1'b0;
  logic [9:0]  wordIn = '0;
  logic        modeDyn = 1'b1, altEn = 1'b0;
  logic [29:0] fixGain = '0, fixOffBase = '0, fixOffEven = '0;
  logic [29:0] offCode, gainCode;
  logic        codeValid, codeOdd;

  always #4 clk = ~clk;

  pix_code_demux i_pix_code_demux (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .pixStart(pixStart),
    .wordValid(wordValid), .wordIn(wordIn), .modeDyn(modeDyn), .altEn(altEn),
    .fixGain(fixGain), .fixOffBase(fixOffBase), .fixOffEven(fixOffEven),
    .offCode(offCode), .gainCode(gainCode), .codeValid(codeValid),
    .codeOdd(codeOdd)
  );

  int nChk = 0, nBad = 0;
  bit done = 1'b0, monOn = 1'b0, prevValid = 1'b0;
  logic [29:0] expOffQ[$], expGainQ[$];
  logic        expOddQ[$];
  string       expTagQ[$];
  logic [29:0] lastOff = '0, lastGain = '0;
  logic        lastOdd = 1'b0;
  bit benchOdd = 1'b0, benchNext = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a set is presented
  always @(negedge clk) begin
    if (monOn) begin
      if (codeValid && prevValid) check("R3 pulse width", 32'd2, 32'd1);
      if (codeValid) begin
        if (expOffQ.size() == 0) begin
          check("R3 unexpected set", 32'd1, 32'd0);
        end else begin
          logic [29:0] eo, eg; logic ed; string t;
          eo = expOffQ.pop_front(); eg = expGainQ.pop_front();
          ed = expOddQ.pop_front(); t = expTagQ.pop_front();
          check({t, " offCode"}, {2'b0, offCode}, {2'b0, eo});
          check({t, " gainCode"}, {2'b0, gainCode}, {2'b0, eg});
          check({t, " codeOdd"}, {31'b0, codeOdd}, {31'b0, ed});
          lastOff = eo; lastGain = eg; lastOdd = ed;
        end
      end
      prevValid = codeValid;
    end
  end

  task automatic notePix(bit ls);
    benchOdd  = ls ? 1'b0 : benchNext;
    benchNext = ~benchOdd;
  endtask

  // outputs must still be the last presented set
  task automatic checkHold(string tag);
    @(negedge clk);
    check({tag, " hold off"}, {2'b0, offCode}, {2'b0, lastOff});
    check({tag, " hold gain"}, {2'b0, gainCode}, {2'b0, lastGain});
  endtask

  // driver: one full pixel; gap inserts idle cycles between words
  task automatic sendPixel(bit ls, logic [59:0] w, int gap, string tag);
    logic [29:0] eo, eg;
    notePix(ls);
    for (int c = 0; c < 3; c++) begin
      if (modeDyn) begin
        eo[c*10 +: 10] = w[(2*c)*10 +: 10];
        eg[c*10 +: 10] = w[(2*c+1)*10 +: 10];
      end else begin
        eo[c*10 +: 10] = (altEn && !benchOdd) ? fixOffEven[c*10 +: 10]
                                              : fixOffBase[c*10 +: 10];
        eg[c*10 +: 10] = fixGain[c*10 +: 10];
      end
    end
    for (int s = 0; s < 6; s++) begin
      if (s > 0) begin
        for (int g = 0; g < gap; g++) begin
          pixStart = 1'b0; lineStart = 1'b0; wordValid = 1'b0;
          wordIn = 10'h3FF;
          @(negedge clk);
        end
      end
      pixStart = (s == 0); lineStart = (s == 0) && ls;
      wordValid = 1'b1; wordIn = w[s*10 +: 10];
      if (s == 5) begin
        expOffQ.push_back(eo); expGainQ.push_back(eg);
        expOddQ.push_back(benchOdd); expTagQ.push_back(tag);
      end
      @(negedge clk);
    end
    pixStart = 1'b0; lineStart = 1'b0; wordValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset offCode", {2'b0, offCode}, 32'd0);
    check("R1 reset gainCode", {2'b0, gainCode}, 32'd0);
    check("R1 reset codeValid", {31'b0, codeValid}, 32'd0);
    check("R1 reset codeOdd", {31'b0, codeOdd}, 32'd0);
    monOn = 1'b1;
    // R1 words before any pixStart are ignored
    for (int i = 0; i < 6; i++) begin
      wordValid = 1'b1; wordIn = 10'(i + 7);
      @(negedge clk);
    end
    wordValid = 1'b0;
    checkHold("R1 no pixStart");

    // R2 dynamic capture, even pixel at line start
    sendPixel(1'b1, {10'h006, 10'h005, 10'h004, 10'h003, 10'h002, 10'h001}, 0, "R2 order");
    idle(2);
    // R2 gaps in wordValid do not advance the slot; R8 odd parity
    sendPixel(1'b0, {10'h3A6, 10'h2B5, 10'h1C4, 10'h0D3, 10'h3E2, 10'h2F1}, 2, "R2 gaps R8");
    idle(1);
    // R4 extra words after blue gain are ignored
    for (int i = 0; i < 4; i++) begin
      wordValid = 1'b1; wordIn = 10'(100 + i);
      @(negedge clk);
    end
    wordValid = 1'b0;
    checkHold("R4 extra words");

    // R5 partial pixel then restart
    notePix(1'b0);
    pixStart = 1'b1; wordValid = 1'b1; wordIn = 10'h111;
    @(negedge clk);
    pixStart = 1'b0; wordIn = 10'h122; @(negedge clk);
    wordIn = 10'h133; @(negedge clk);
    wordValid = 1'b0;
    checkHold("R5 partial");
    sendPixel(1'b0, {10'h01F, 10'h02E, 10'h03D, 10'h04C, 10'h05B, 10'h06A}, 0, "R5 restart");
    idle(2);

    // R6 fixed codes
    fixGain    = {10'h155, 10'h0AA, 10'h333};
    fixOffBase = {10'h101, 10'h202, 10'h303};
    fixOffEven = {10'h011, 10'h022, 10'h033};
    modeDyn = 1'b0; altEn = 1'b0;
    sendPixel(1'b1, {10'h3FF, 10'h3FE, 10'h3FD, 10'h3FC, 10'h3FB, 10'h3FA}, 0, "R6 fixed even");
    sendPixel(1'b0, {10'h001, 10'h002, 10'h003, 10'h004, 10'h005, 10'h006}, 1, "R6 fixed odd");
    idle(2);

    // R7 alternate-pixel offsets across a line of four pixels
    altEn = 1'b1;
    sendPixel(1'b1, {6{10'h2AA}}, 0, "R7 even0");
    sendPixel(1'b0, {6{10'h155}}, 0, "R7 odd1");
    sendPixel(1'b0, {6{10'h0F0}}, 0, "R7 even2");
    sendPixel(1'b0, {6{10'h00F}}, 0, "R7 odd3");
    idle(2);

    // R8 lone lineStart makes the next pixel even
    lineStart = 1'b1; @(negedge clk); lineStart = 1'b0;
    benchNext = 1'b0;
    sendPixel(1'b0, {6{10'h321}}, 0, "R8 lone line");
    sendPixel(1'b0, {6{10'h123}}, 0, "R8 toggle");
    idle(2);

    // R9 dynamic mode ignores altEn
    modeDyn = 1'b1; altEn = 1'b1;
    sendPixel(1'b1, {10'h0C6, 10'h0B5, 10'h0A4, 10'h093, 10'h082, 10'h071}, 0, "R9 dyn alt even");
    sendPixel(1'b0, {10'h1C6, 10'h1B5, 10'h1A4, 10'h193, 10'h182, 10'h171}, 0, "R9 dyn alt odd");
    idle(4);
    check("R3 all sets presented", expOffQ.size(), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++; nBad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule